// File: doc/BRIEF.md
# SCSI Command Legality Decoder

This block sits behind the command register of a SCSI protocol controller. Each byte written there is split into a DMA request flag (bit 7) and a 7-bit operation code. The code is sorted into one of four command groups or marked as undefined. The group is then compared with the controller's present connection state. A command that is legal in that state leaves the block as a one-cycle dispatch pulse that carries the opcode and the DMA flag. A command that is not legal raises the illegal-command interrupt and is not dispatched.

The block also holds the pending interrupt register. The bus engine sets the event bits 0 to 5 through a set vector. The decoder sets bit 6 for an illegal command and bit 7 for an accepted bus-reset command; a configuration input can suppress the bit 7 report. Software reads the register through a read strobe, which returns the pending bits and clears them. The interrupt line, and its copy used as status bit 7, is the OR of the pending bits.

Top module: `scsi_cmd_gate`

## Requirements
- R1: After reset, no dispatch pulse is present, the pending interrupt register is 0, and the interrupt line and status interrupt flag are low.
- R2: A legal command written in cycle k produces `disp_vld` high for exactly one cycle after that clock edge. `disp_op` carries bits 6:0 of the byte and `disp_dma` carries bit 7. Bit 7 has no effect on legality.
- R3: Codes 0x00, 0x01, 0x02 and 0x03 are legal in every value of `link_state`. The encodings are 0 disconnected, 1 connected as initiator, 2 connected as initiator in a message phase, and 3 reserved.
- R4: Codes 0x10, 0x11, 0x12, 0x18, 0x1A and 0x1B are legal only when `link_state` is 1 or 2.
- R5: Codes 0x20 through 0x25, 0x27, and 0x28 through 0x2B are legal only when `link_state` is 2.
- R6: Codes 0x40 through 0x47 are legal only when `link_state` is 0.
- R7: A command that is not legal in the present state is not dispatched. It sets interrupt bit 6 in the cycle after the write.
- R8: Every code outside the four groups (for example 0x04, 0x13, 0x26, 0x48, 0x7F) is illegal in every state. This includes reserved state 3, where only codes 0x00 to 0x03 are legal.
- R9: An accepted code 0x03 sets interrupt bit 7 unless `quiet_bus_reset` is high. Codes 0x00 to 0x02 set no interrupt bit.
- R10: `irq_pend` shows the pending bits. An `irq_rd` cycle clears them at the next edge, except that a bit being set in that same cycle stays pending.
- R11: `irq_line` and `stat_intr` are high exactly when any pending bit is set.
- R12: A high bit i of `evt_set` (bits 0 to 5) sets interrupt bit i in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_byte | input | 8 | Written command byte, bit 7 is the DMA flag |
| link_state | input | 2 | Connection state: 0 disconnected, 1 connected, 2 message phase, 3 reserved |
| quiet_bus_reset | input | 1 | Suppresses the bus-reset interrupt report |
| evt_set | input | 6 | Event bits from the bus engine, one per interrupt bit 0 to 5 |
| irq_rd | input | 1 | Interrupt register read strobe (read clears) |
| disp_vld | output | 1 | One-cycle dispatch pulse |
| disp_op | output | 7 | Dispatched operation code |
| disp_dma | output | 1 | Dispatched DMA flag |
| irq_pend | output | 8 | Pending interrupt register contents |
| irq_line | output | 1 | Interrupt request line |
| stat_intr | output | 1 | Status register interrupt flag (bit 7) |

## Verification
The bound checker tests these properties on every cycle:
- every dispatch follows a write and matches the written byte;
- a write that is not dispatched leaves bit 6 pending;
- dispatched selection-group and message-group codes occur only in their own states;
- a read with no new sets empties the register;
- the interrupt line follows the pending bits.

Some behaviours appear only in the bench's scenarios. These are the full legality table across all four states, the treatment of undefined codes, the quiet option for the bus-reset report, event setting, and a set that coincides with a read.

// File: rtl/cmdgate_pkg.sv
package cmdgate_pkg;
   typedef enum logic [1:0] {
      LS_DISC = 2'd0,
      LS_CONN = 2'd1,
      LS_MSG  = 2'd2,
      LS_RSVD = 2'd3
   } link_state_e;

   typedef enum logic [2:0] {
      GRP_ANY   = 3'd0,
      GRP_CONN  = 3'd1,
      GRP_MSG   = 3'd2,
      GRP_SEL   = 3'd3,
      GRP_UNDEF = 3'd4
   } cmd_grp_e;

   localparam int unsigned IRQ_ILLEGAL_BIT = 6;
   localparam int unsigned IRQ_BUSRST_BIT  = 7;
   localparam logic [6:0]  OP_BUS_RESET    = 7'h03;
endpackage

// File: rtl/cmdgate_classify.sv
module cmdgate_classify
   import cmdgate_pkg::*;
#(
   parameter int unsigned OP_W = 7
) (
   input  logic [OP_W-1:0] op,
   output cmd_grp_e        grp
);
   always_comb begin
      grp = GRP_UNDEF;
      unique casez (op)
         7'b000_00??:                         grp = GRP_ANY;
         7'h10, 7'h11, 7'h12,
         7'h18, 7'h1A, 7'h1B:                 grp = GRP_CONN;
         7'b010_0???, 7'b010_10??:            grp = (op == 7'h26) ? GRP_UNDEF : GRP_MSG;
         7'b100_0???:                         grp = GRP_SEL;
         default:                             grp = GRP_UNDEF;
      endcase
   end
endmodule

// File: rtl/cmdgate_legal.sv
module cmdgate_legal
   import cmdgate_pkg::*;
#(
   parameter bit MSG_IS_CONNECTED = 1'b1
) (
   input  cmd_grp_e    grp,
   input  link_state_e st,
   output logic        legal
);
   logic conn_ok;

   generate
      if (MSG_IS_CONNECTED) begin : g_msg_conn
         assign conn_ok = (st == LS_CONN) || (st == LS_MSG);
      end else begin : g_conn_only
         assign conn_ok = (st == LS_CONN);
      end
   endgenerate

   always_comb begin
      unique case (grp)
         GRP_ANY:  legal = 1'b1;
         GRP_CONN: legal = conn_ok;
         GRP_MSG:  legal = (st == LS_MSG);
         GRP_SEL:  legal = (st == LS_DISC);
         default:  legal = 1'b0;
      endcase
   end
endmodule

// File: rtl/cmdgate_irqreg.sv
module cmdgate_irqreg #(
   parameter int unsigned IRQ_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IRQ_W-1:0] set_v,
   input  logic             clr,
   output logic [IRQ_W-1:0] pend
);
   generate
      for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n)         pend[i] <= 1'b0;
            else if (set_v[i])  pend[i] <= 1'b1;
            else if (clr)       pend[i] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/scsi_cmd_gate.sv
module scsi_cmd_gate
   import cmdgate_pkg::*;
#(
   parameter int unsigned CMD_W = 8,
   parameter int unsigned IRQ_W = 8,
   parameter int unsigned EVT_W = 6,
   parameter bit          MSG_IS_CONNECTED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [CMD_W-1:0] cmd_byte,
   input  logic [1:0]       link_state,
   input  logic             quiet_bus_reset,
   input  logic [EVT_W-1:0] evt_set,
   input  logic             irq_rd,
   output logic             disp_vld,
   output logic [CMD_W-2:0] disp_op,
   output logic             disp_dma,
   output logic [IRQ_W-1:0] irq_pend,
   output logic             irq_line,
   output logic             stat_intr
);
   localparam int unsigned OP_W = CMD_W - 1;

   if (CMD_W != 8) begin : g_bad_cmd_w
      $error("scsi_cmd_gate: CMD_W must be 8");
   end
   if (IRQ_W != 8) begin : g_bad_irq_w
      $error("scsi_cmd_gate: IRQ_W must be 8");
   end
   if (EVT_W > IRQ_ILLEGAL_BIT) begin : g_bad_evt_w
      $error("scsi_cmd_gate: EVT_W overlaps decoder-owned bits");
   end

   logic [OP_W-1:0]  op;
   cmd_grp_e         grp;
   logic             legal;
   logic [IRQ_W-1:0] set_v;

   assign op = cmd_byte[OP_W-1:0];

   cmdgate_classify #(.OP_W(OP_W)) u_classify (
      .op  (op),
      .grp (grp)
   );

   cmdgate_legal #(.MSG_IS_CONNECTED(MSG_IS_CONNECTED)) u_legal (
      .grp   (grp),
      .st    (link_state_e'(link_state)),
      .legal (legal)
   );

   always_comb begin
      set_v = '0;
      set_v[EVT_W-1:0]       = evt_set;
      set_v[IRQ_ILLEGAL_BIT] = cmd_wr && !legal;
      set_v[IRQ_BUSRST_BIT]  = cmd_wr && legal && (op == OP_BUS_RESET) && !quiet_bus_reset;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         disp_vld <= 1'b0;
         disp_op  <= '0;
         disp_dma <= 1'b0;
      end else begin
         disp_vld <= cmd_wr && legal;
         if (cmd_wr && legal) begin
            disp_op  <= op;
            disp_dma <= cmd_byte[CMD_W-1];
         end
      end
   end

   cmdgate_irqreg #(.IRQ_W(IRQ_W)) u_irqreg (
      .clk   (clk),
      .rst_n (rst_n),
      .set_v (set_v),
      .clr   (irq_rd),
      .pend  (irq_pend)
   );

   assign irq_line  = |irq_pend;
   assign stat_intr = irq_line;
endmodule

// File: rtl/cmdgate_chk.sv
module cmdgate_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_wr,
   input logic [7:0] cmd_byte,
   input logic [1:0] link_state,
   input logic [5:0] evt_set,
   input logic       irq_rd,
   input logic       disp_vld,
   input logic [6:0] disp_op,
   input logic       disp_dma,
   input logic [7:0] irq_pend,
   input logic       irq_line
);
   a_r2_dispatch_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      disp_vld |-> $past(cmd_wr) && ({disp_dma, disp_op} == $past(cmd_byte)));

   a_r7_refused_sets_bit6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmd_wr) && !disp_vld |-> irq_pend[6]);

   a_r5_msg_group_state: assert property (@(posedge clk) disable iff (!rst_n)
      disp_vld && (disp_op[6:4] == 3'b010) |-> $past(link_state) == 2'd2);

   a_r6_sel_group_state: assert property (@(posedge clk) disable iff (!rst_n)
      disp_vld && disp_op[6] |-> $past(link_state) == 2'd0);

   a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      $past(irq_rd) && !$past(cmd_wr) && ($past(evt_set) == 6'd0) |-> irq_pend == 8'd0);

   a_r11_line_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      irq_line == (irq_pend != 8'd0));
endmodule

bind scsi_cmd_gate cmdgate_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_wr     (cmd_wr),
   .cmd_byte   (cmd_byte),
   .link_state (link_state),
   .evt_set    (evt_set),
   .irq_rd     (irq_rd),
   .disp_vld   (disp_vld),
   .disp_op    (disp_op),
   .disp_dma   (disp_dma),
   .irq_pend   (irq_pend),
   .irq_line   (irq_line)
);

// File: tb/scsi_cmd_gate_bench.sv
module scsi_cmd_gate_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_wr = 1'b0;
   logic [7:0] cmd_byte = 8'h00;
   logic [1:0] link_state = 2'd0;
   logic       quiet_bus_reset = 1'b0;
   logic [5:0] evt_set = 6'd0;
   logic       irq_rd = 1'b0;
   logic       disp_vld;
   logic [6:0] disp_op;
   logic       disp_dma;
   logic [7:0] irq_pend;
   logic       irq_line;
   logic       stat_intr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [7:0] exp_q[$];

   always #2 clk = ~clk;

   scsi_cmd_gate u_scsi_cmd_gate (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
      .link_state(link_state), .quiet_bus_reset(quiet_bus_reset),
      .evt_set(evt_set), .irq_rd(irq_rd), .disp_vld(disp_vld),
      .disp_op(disp_op), .disp_dma(disp_dma), .irq_pend(irq_pend),
      .irq_line(irq_line), .stat_intr(stat_intr)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected dispatches as the design produces them
   always @(negedge clk) begin
      if (rst_n && disp_vld) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R7 unexpected dispatch", {disp_dma, disp_op}, 0);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk({disp_dma, disp_op} == e, "R2 dispatch content", {disp_dma, disp_op}, e);
         end
      end
   end

   task automatic read_clear(input logic [7:0] exp_rd, input logic [7:0] exp_after);
      irq_rd = 1'b1;
      #1;
      chk(irq_pend == exp_rd, "R10 read data", irq_pend, exp_rd);
      @(negedge clk);
      irq_rd  = 1'b0;
      evt_set = 6'd0;
      chk(irq_pend == exp_after, "R10 after read", irq_pend, exp_after);
      chk(disp_vld == 1'b0, "R2 single-cycle pulse", disp_vld, 0);
      chk(irq_line == (exp_after != 0) && stat_intr == (exp_after != 0),
          "R11 line follows pending", {irq_line, stat_intr}, {2{exp_after != 0}});
   endtask

   task automatic send(input logic [7:0] b, input logic [1:0] st, input bit legal,
                       input logic [7:0] exp_p, input string tag);
      @(negedge clk);
      cmd_byte = b; link_state = st; cmd_wr = 1'b1;
      if (legal) exp_q.push_back(b);
      @(negedge clk);
      cmd_wr = 1'b0;
      chk(irq_pend == exp_p, tag, irq_pend, exp_p);
      chk(disp_vld == legal, tag, disp_vld, legal);
      read_clear(exp_p, 8'h00);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(disp_vld == 0 && irq_pend == 0 && !irq_line && !stat_intr, "R1 reset state",
          {disp_vld, irq_pend, irq_line, stat_intr}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(irq_pend == 0 && !irq_line, "R1 after release", irq_pend, 0);

      // R3 group one in all states, R9 no interrupt for 0x00..0x02
      for (int s = 0; s < 4; s++) begin
         send(8'h00, 2'(s), 1'b1, 8'h00, "R3 nop any state");
         send(8'h01, 2'(s), 1'b1, 8'h00, "R3 flush any state");
         send(8'h82, 2'(s), 1'b1, 8'h00, "R9 chip reset no irq");
         send(8'h03, 2'(s), 1'b1, 8'h80, "R9 bus reset reported");
      end
      quiet_bus_reset = 1'b1;
      send(8'h03, 2'd1, 1'b1, 8'h00, "R9 bus reset quiet");
      quiet_bus_reset = 1'b0;

      // R4 connected group
      send(8'h10, 2'd1, 1'b1, 8'h00, "R4 legal connected");
      send(8'h9A, 2'd2, 1'b1, 8'h00, "R4 legal message phase DMA");
      send(8'h1B, 2'd0, 1'b0, 8'h40, "R4 illegal disconnected");
      send(8'h18, 2'd3, 1'b0, 8'h40, "R4 illegal reserved");

      // R5 message group
      send(8'h20, 2'd2, 1'b1, 8'h00, "R5 legal msg");
      send(8'hAB, 2'd2, 1'b1, 8'h00, "R5 legal msg top DMA");
      send(8'h27, 2'd2, 1'b1, 8'h00, "R5 legal 0x27");
      send(8'h25, 2'd1, 1'b0, 8'h40, "R5 illegal connected");
      send(8'h28, 2'd0, 1'b0, 8'h40, "R5 illegal disconnected");

      // R6 selection group
      send(8'hC1, 2'd0, 1'b1, 8'h00, "R6 legal select DMA");
      send(8'h47, 2'd0, 1'b1, 8'h00, "R6 legal 0x47");
      send(8'h42, 2'd1, 1'b0, 8'h40, "R6 illegal connected");
      send(8'h40, 2'd2, 1'b0, 8'h40, "R7 illegal message phase");

      // R8 undefined codes
      for (int s = 0; s < 4; s++) begin
         send(8'h04, 2'(s), 1'b0, 8'h40, "R8 undefined 0x04");
         send(8'h13, 2'(s), 1'b0, 8'h40, "R8 undefined 0x13");
         send(8'h26, 2'(s), 1'b0, 8'h40, "R8 undefined 0x26");
         send(8'h48, 2'(s), 1'b0, 8'h40, "R8 undefined 0x48");
         send(8'hFF, 2'(s), 1'b0, 8'h40, "R8 undefined 0x7F");
      end

      // R12 events
      @(negedge clk);
      evt_set = 6'h21;
      @(negedge clk);
      evt_set = 6'd0;
      chk(irq_pend == 8'h21, "R12 event bits", irq_pend, 8'h21);
      chk(irq_line && stat_intr, "R11 line high", {irq_line, stat_intr}, 3);
      @(negedge clk);
      chk(irq_pend == 8'h21, "R10 held without read", irq_pend, 8'h21);
      // R10 set coinciding with read stays pending
      evt_set = 6'h10;
      read_clear(8'h21, 8'h10);
      read_clear(8'h10, 8'h00);

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R2 all dispatches seen", exp_q.size(), 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule